// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

Two independent 16-bit up-counters live behind a small 16-bit register interface (byte address, write strobe, write data, read strobe, read data). Each channel owns a control register, a counter register and a compare register. A shared two-bit start register lets each channel run. A running channel advances its counter once per prescaled tick. The tick comes from the system clock, divided by one of four ratios that the channel's control register selects.

When a tick arrives while the counter equals the compare value, the counter loads zero instead of incrementing. The channel may then emit a single-clock interrupt pulse, gated by its own enable bit. Software can rewrite the counter and compare values at any moment, and later match detection uses the new values.

The register window is 16 bytes. Counter and control registers are read combinationally while the read strobe is high. Offsets that hold no register read as all ones and discard writes.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, the start register, both control registers and both counters read 0x0000, and both compare registers read 0xFFFF.
- R2: Byte offsets are: 0 for start, 2/4/6 for channel 0 control/counter/compare, and 8/10/12 for channel 1 control/counter/compare. In the start register, bit 0 runs channel 0 and bit 1 runs channel 1. A start read returns those two bits with all upper bits zero.
- R3: Control bits [1:0] are the divide code and bit 6 is the interrupt enable. All other control bits read 0 and ignore writes.
- R4: A running channel with divide code k increments its counter once every 2^(3+2k) system clocks (8, 32, 128 or 512).
- R5: On a tick that finds the counter equal to the compare value, the counter becomes 0 and counting goes on, so one match period is (compare+1) ticks.
- R6: Each match drives the channel's interrupt output high for exactly one clock, in the cycle after the matching tick, and only when the channel's enable bit is 1.
- R7: While a channel's start bit is 0, its counter holds its value and its interrupt output stays low.
- R8: Writes to the counter or compare register take effect at once, whether the channel is running or stopped, and later matches use the new values.
- R9: Reads of odd offsets and of offset 14 return 0xFFFF, and writes to those offsets change no register.
- R10: A channel's prescaler restarts from zero whenever its start bit goes from 0 to 1, so the first tick comes a full divide period after the start write.
- R11: The two channels count, match and interrupt independently of each other's settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data (combinational, zero when no read) |
| irq_o | output | 2 | Per-channel compare-match interrupt pulse |

## Verification
Directed cases cover the following:
- every reset value and the bits each register keeps;
- the slowest-but-one ratio, to separate an off-by-one in the divide period from a wrong ratio;
- a stop/restart sequence, which separates a prescaler that restarts from one that keeps its phase;
- a small compare value run with one channel enabled and one masked, which separates clear-on-match and interrupt gating from cross-channel leakage.

Randomized runs then draw divide codes, compare values, enable bits, junk upper control bits and run lengths. They compare both counters and the number of interrupt pulses with a closed-form model: floor(cycles/ratio) mod (compare+1) for the counter, and floor(cycles/(ratio*(compare+1))) for the pulses. This exposes errors in period length that a single fixed pattern could hide.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    // register map geometry (byte offsets)
    localparam int OFF_START  = 0;
    localparam int CH_BASE    = 2;
    localparam int CH_STRIDE  = 6;
    localparam int IE_BIT     = 6;

    // which per-channel register an address selects
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CNT  = 2'd1,
        REG_CMP  = 2'd2,
        REG_NONE = 2'd3
    } ch_reg_e;

endpackage

// File: rtl/cmt_decode.sv
module cmt_decode
    import cmt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NUM_CH = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              sel_start_o,
    output logic [NUM_CH-1:0] ch_sel_o,
    output ch_reg_e           ch_reg_o,
    output logic              hit_o
);

    always_comb begin
        sel_start_o = (int'(addr_i) == OFF_START);
        ch_sel_o    = '0;
        ch_reg_o    = REG_NONE;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(addr_i) == CH_BASE + CH_STRIDE * c) begin
                ch_sel_o[c] = 1'b1;
                ch_reg_o    = REG_CTRL;
            end else if (int'(addr_i) == CH_BASE + CH_STRIDE * c + 2) begin
                ch_sel_o[c] = 1'b1;
                ch_reg_o    = REG_CNT;
            end else if (int'(addr_i) == CH_BASE + CH_STRIDE * c + 4) begin
                ch_sel_o[c] = 1'b1;
                ch_reg_o    = REG_CMP;
            end
        end
        hit_o = sel_start_o | (|ch_sel_o);
    end

endmodule

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
    parameter int CKS_W    = 2,
    parameter int BASE_LOG = 3,
    parameter int STEP_LOG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CKS_W-1:0] cks_i,
    output logic             tick_o
);

    localparam int PRE_W = BASE_LOG + STEP_LOG * ((1 << CKS_W) - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pcnt;
    } pre_state_t;

    pre_state_t q, d;
    logic [PRE_W:0]   full;
    logic [PRE_W-1:0] lim;

    always_comb begin
        full   = (PRE_W + 1)'(1) << (BASE_LOG + STEP_LOG * int'(cks_i));
        lim    = PRE_W'(full - 1'b1);
        tick_o = run_i && (q.pcnt >= lim);
        d      = q;
        if (!run_i) begin
            d.pcnt = '0;
        end else if (tick_o) begin
            d.pcnt = '0;
        end else begin
            d.pcnt = q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CKS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_cnt_i,
    input  logic              wr_cmp_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CKS_W-1:0]  cks_o,
    output logic              ie_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] cmp_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] cmp;
        logic [CKS_W-1:0]  cks;
        logic              ie;
        logic              irq;
    } ch_state_t;

    ch_state_t q, d;

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (tick_i) begin
            if (q.cnt == q.cmp) begin
                d.cnt = '0;
                d.irq = q.ie;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        if (wr_ctrl_i) begin
            d.cks = wdata_i[CKS_W-1:0];
            d.ie  = wdata_i[IE_BIT];
        end
        if (wr_cnt_i) begin
            d.cnt = wdata_i;
        end
        if (wr_cmp_i) begin
            d.cmp = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
            q.cmp <= '1;
            q.cks <= '0;
            q.ie  <= 1'b0;
            q.irq <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cks_o = q.cks;
    assign ie_o  = q.ie;
    assign cnt_o = q.cnt;
    assign cmp_o = q.cmp;
    assign irq_o = q.irq;

endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import cmt_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int NUM_CH   = 2,
    parameter int CKS_W    = 2,
    parameter int BASE_LOG = 3,
    parameter int STEP_LOG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] start;
    } top_state_t;

    top_state_t q, d;

    logic              sel_start;
    logic [NUM_CH-1:0] ch_sel;
    ch_reg_e           ch_reg;
    logic              hit;

    logic [NUM_CH-1:0]             wr_ctrl, wr_cnt, wr_cmp, tick, ie_w;
    logic [NUM_CH-1:0][CKS_W-1:0]  cks_w;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_w, cmp_w;
    logic [NUM_CH-1:0]             start_w;

    cmt_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH)
    ) u_decode (
        .addr_i      (bus_addr),
        .sel_start_o (sel_start),
        .ch_sel_o    (ch_sel),
        .ch_reg_o    (ch_reg),
        .hit_o       (hit)
    );

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            wr_ctrl[c] = bus_wr && ch_sel[c] && (ch_reg == REG_CTRL);
            wr_cnt[c]  = bus_wr && ch_sel[c] && (ch_reg == REG_CNT);
            wr_cmp[c]  = bus_wr && ch_sel[c] && (ch_reg == REG_CMP);
        end
    end

    always_comb begin
        d = q;
        if (bus_wr && sel_start) begin
            d.start = bus_wdata[NUM_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign start_w = q.start;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cmt_prescaler #(
            .CKS_W    (CKS_W),
            .BASE_LOG (BASE_LOG),
            .STEP_LOG (STEP_LOG)
        ) u_pre (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (q.start[g]),
            .cks_i  (cks_w[g]),
            .tick_o (tick[g])
        );

        cmt_channel #(
            .DATA_W (DATA_W),
            .CKS_W  (CKS_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick[g]),
            .wr_ctrl_i (wr_ctrl[g]),
            .wr_cnt_i  (wr_cnt[g]),
            .wr_cmp_i  (wr_cmp[g]),
            .wdata_i   (bus_wdata),
            .cks_o     (cks_w[g]),
            .ie_o      (ie_w[g]),
            .cnt_o     (cnt_w[g]),
            .cmp_o     (cmp_w[g]),
            .irq_o     (irq_o[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            bus_rdata = '1;
            if (sel_start) begin
                bus_rdata                = '0;
                bus_rdata[NUM_CH-1:0]    = q.start;
            end else if (hit) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (ch_sel[c]) begin
                        unique case (ch_reg)
                            REG_CTRL: begin
                                bus_rdata             = '0;
                                bus_rdata[CKS_W-1:0]  = cks_w[c];
                                bus_rdata[IE_BIT]     = ie_w[c];
                            end
                            REG_CNT:  bus_rdata = cnt_w[c];
                            REG_CMP:  bus_rdata = cmp_w[c];
                            default:  bus_rdata = '1;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/cmt_checker.sv
module cmt_checker #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4,
    parameter int NUM_CH = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_rd,
    input  logic [DATA_W-1:0]              bus_rdata,
    input  logic [NUM_CH-1:0]              start,
    input  logic [NUM_CH-1:0]              wr_cnt,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  cnt,
    input  logic [NUM_CH-1:0]              irq
);

    AST_ODD_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[0]) |-> (bus_rdata == {DATA_W{1'b1}})); // R9

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |=> !irq[c]); // R6

        AST_STOPPED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            !start[c] |=> !irq[c]); // R7

        AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!start[c] && !wr_cnt[c]) |=> $stable(cnt[c])); // R7

        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (start[c] && !wr_cnt[c]) |=>
                (cnt[c] == $past(cnt[c]) || cnt[c] == $past(cnt[c]) + 1'b1
                 || cnt[c] == '0)); // R4

        AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[c] && !$past(wr_cnt[c])) |-> (cnt[c] == '0)); // R5
    end

endmodule

bind dual_match_timer cmt_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .start     (start_w),
    .wr_cnt    (wr_cnt),
    .cnt       (cnt_w),
    .irq       (irq_o)
);

// File: tb/dual_match_timer_tb.sv
module dual_match_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_match_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    function automatic int ratio(input int code);
        return 1 << (3 + 2 * code);
    endfunction

    function automatic int exp_cnt(input int n, input int code, input int cmp);
        return (n / ratio(code)) % (cmp + 1);
    endfunction

    function automatic int exp_irq(input int n, input int code, input int cmp, input bit ie);
        return ie ? n / (ratio(code) * (cmp + 1)) : 0;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        bus_addr  = 4'(a);
        bus_wdata = 16'(v);
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        bus_addr = 4'(a);
        bus_rd   = 1'b1;
        #1;
        v = int'(bus_rdata);
        bus_rd   = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input int expv);
        int v;
        rd(a, v);
        check(req, v, expv);
    endtask

    // run n clock edges, counting irq pulses and back-to-back highs
    task automatic run(input int n, output int p0, output int p1, output int dbl);
        bit last0 = 0, last1 = 0;
        p0 = 0; p1 = 0; dbl = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_o[0]) p0++;
            if (irq_o[1]) p1++;
            if ((irq_o[0] && last0) || (irq_o[1] && last1)) dbl++;
            last0 = irq_o[0];
            last1 = irq_o[1];
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0, p1, dbl;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd_check("R1 start", 0, 16'h0000);
        rd_check("R1 ctrl0", 2, 16'h0000);
        rd_check("R1 cnt0", 4, 16'h0000);
        rd_check("R1 cmp0", 6, 16'hFFFF);
        rd_check("R1 ctrl1", 8, 16'h0000);
        rd_check("R1 cnt1", 10, 16'h0000);
        rd_check("R1 cmp1", 12, 16'hFFFF);

        // R9 unmapped offsets
        rd_check("R9 read off14", 14, 16'hFFFF);
        rd_check("R9 read off3", 3, 16'hFFFF);
        wr(14, 16'hFFFF);
        wr(7, 16'h1234);
        wr(5, 16'h00FF);
        rd_check("R9 cnt0 untouched", 4, 16'h0000);
        rd_check("R9 cmp0 untouched", 6, 16'hFFFF);
        rd_check("R9 start untouched", 0, 16'h0000);

        // R2 start register keeps two bits
        wr(0, 16'hFFFF);
        rd_check("R2 start bits", 0, 16'h0003);
        wr(0, 0);
        wr(4, 0);
        wr(10, 0);

        // R3 control fields
        wr(2, 16'hFFFF);
        rd_check("R3 ctrl0 all ones", 2, 16'h0043);
        wr(8, 16'hFFBC);
        rd_check("R3 ctrl1 junk", 8, 16'h0000);

        // R4 ratio 128 (code 2)
        wr(2, 2);
        wr(0, 1);
        run(3 * 128 - 1, p0, p1, dbl);
        rd_check("R4 cnt0 before third tick", 4, 2);
        run(1, p0, p1, dbl);
        rd_check("R4 cnt0 at third tick", 4, 3);
        rd_check("R11 cnt1 idle", 10, 0);
        wr(0, 0);

        // R10 prescaler restart
        wr(4, 0);
        wr(2, 0);
        wr(0, 1);
        run(5, p0, p1, dbl);
        wr(0, 0);
        rd_check("R10 cnt0 after partial period", 4, 0);
        wr(0, 1);
        run(7, p0, p1, dbl);
        rd_check("R10 no early tick", 4, 0);
        run(1, p0, p1, dbl);
        rd_check("R10 tick after full period", 4, 1);
        wr(0, 0);

        // R5 R6 R11 small compare, one channel masked
        wr(4, 0);
        wr(10, 0);
        wr(2, 16'h0000);
        wr(6, 2);
        wr(8, 16'h0040);
        wr(12, 2);
        wr(0, 3);
        run(48, p0, p1, dbl);
        check("R6 masked ch0 pulses", p0, 0);
        check("R6 enabled ch1 pulses", p1, 2);
        check("R6 pulse width", dbl, 0);
        rd_check("R5 cnt0 wrapped", 4, 0);
        rd_check("R11 cnt1 wrapped", 10, 0);

        // R7 stopped channel holds
        wr(0, 0);
        wr(10, 16'h0077);
        run(100, p0, p1, dbl);
        rd_check("R7 cnt1 held", 10, 16'h0077);
        check("R7 no pulses stopped", p0 + p1, 0);

        // R8 software writes
        wr(6, 6);
        wr(4, 5);
        wr(2, 16'h0040);
        wr(0, 1);
        run(8, p0, p1, dbl);
        rd_check("R8 cnt0 from written value", 4, 6);
        run(8, p1, p0, dbl);
        check("R8 match on written compare", p1, 1);
        rd_check("R8 cleared after match", 4, 0);
        wr(4, 16'h0100);
        rd_check("R8 running cnt write", 4, 16'h0100);

        // randomized runs
        for (int it = 0; it < 10; it++) begin
            int k0, k1, c0, c1, n, v;
            bit e0, e1;
            k0 = int'($urandom % 2);
            k1 = int'($urandom % 2);
            c0 = int'($urandom % 8);
            c1 = int'($urandom % 8);
            e0 = 1'($urandom);
            e1 = 1'($urandom);
            n  = 50 + int'($urandom % 1500);
            wr(0, 0);
            wr(4, 0);
            wr(10, 0);
            wr(2, int'(($urandom & 32'hFFBC)) | (int'(e0) << 6) | k0);
            wr(8, int'(($urandom & 32'hFFBC)) | (int'(e1) << 6) | k1);
            wr(6, c0);
            wr(12, c1);
            wr(0, 3);
            run(n, p0, p1, dbl);
            rd(4, v);
            check("R5 random cnt0", v, exp_cnt(n, k0, c0));
            rd(10, v);
            check("R11 random cnt1", v, exp_cnt(n, k1, c1));
            check("R6 random irq0", p0, exp_irq(n, k0, c0, e0));
            check("R6 random irq1", p1, exp_irq(n, k1, c1, e1));
            check("R6 random width", dbl, 0);
            rd(2, v);
            check("R3 random ctrl0", v, (int'(e0) << 6) | k0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule